// File: doc/BRIEF.md
# Multi-mode serial FIFO data port

This block is the bus-facing data window of a serial controller. It holds two byte-wide queues of 512 bytes each, one for transmit and one for receive. Both sit behind a single 32-bit data register: a bus write loads bytes into the transmit queue, and a bus read takes bytes out of the receive queue. A second write path, the alias path, also loads the transmit queue but is never gated.

A mode input sets how each bus word maps to queue bytes. The byte-stream modes pass 1, 2 or 4 bytes per access. The 16-bit codec mode passes 2 or 4. The 24-bit codec mode moves three bytes per word and the 32-bit codec mode moves four. The audio-link sample mode moves one 20-bit sample per word, and that sample carries a start-of-frame marker. Accesses of a size the mode does not allow are refused. The same happens to writes with no room and to reads with too little data, and each case sets a sticky flag.

The serial engines sit on the far side of the queues. They use a one-byte-per-cycle pop port on the transmit queue and a one-byte-per-cycle push port on the receive queue. Both fill levels are reported in bytes.

Top module: `serdata_port`

## Requirements
- R1: After reset, both fill levels are 0 and `size_err`, `tx_overflow`, `rx_underflow` and `bus_rdata` are all 0.
- R2: Modes 0, 1 and 2 (byte stream) accept size codes 0, 1 and 2, which mean 1, 2 and 4 bytes. Byte lane k is bits 8k+7:8k, and lane 0 is the earliest byte in the stream. A read returns the popped bytes in the low lanes, and every unused lane reads as zero.
- R3: Mode 3 (16-bit codec) accepts only size codes 1 and 2 (2 or 4 bytes), with the same lane order as R2.
- R4: Mode 4 (24-bit codec) accepts only size code 2. A write queues bits 23:0 as three bytes, low lane first. A read pops three bytes and returns bits 31:24 as zero.
- R5: Mode 5 (32-bit codec) accepts only size code 2 and moves four bytes per access, low lane first.
- R6: Mode 6 (audio-link samples) accepts only size code 2, and each access moves one sample as three queue bytes. Bits 19:0 hold the sample and bit 20 is the start-of-frame flag. Bits 31:21 are dropped on write and read as zero. When bit 20 is 1, the sample is the 16-bit tag slot and bits 19:16 are forced to zero. In the third queue byte, bit 4 holds the flag and bits 3:0 hold sample bits 19:16.
- R7: An access with a size the mode does not allow leaves both queues unchanged. Size code 3 and mode 7 are never allowed. Such an access sets `size_err` on the next cycle. `size_err` then stays set until reset.
- R8: In modes 0 and 1, a write with `bus_alias` low while `tx_enable` is low is discarded and sets no flag. Alias writes, and writes in all other modes, do not depend on `tx_enable`.
- R9: A write whose byte count exceeds the free transmit space is dropped whole and sets the sticky `tx_overflow`.
- R10: A read asking for more bytes than the receive queue holds pops nothing, returns 0 and sets the sticky `rx_underflow`.
- R11: The fill levels count bytes, up to 512. `tx_pop` removes the oldest byte, which is shown on `tx_data`, and is ignored when the queue is empty. `rx_push` queues `rx_data` and is ignored when the queue is full.
- R12: `bus_rdata` changes only in the cycle after a `bus_rd`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Framing mode, 0..7 |
| tx_enable | input | 1 | Transmitter enabled; gates non-alias writes in modes 0 and 1 |
| bus_wr | input | 1 | Write strobe for the data register |
| bus_rd | input | 1 | Read strobe for the data register |
| bus_alias | input | 1 | Write goes through the never-gated alias path |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| size_err | output | 1 | Sticky flag for a refused access size |
| tx_overflow | output | 1 | Sticky flag for a dropped write |
| rx_underflow | output | 1 | Sticky flag for a short read |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_level | output | 10 | Transmit fill level in bytes |
| rx_push | input | 1 | Engine delivers one receive byte |
| rx_data | input | 8 | Received byte |
| rx_level | output | 10 | Receive fill level in bytes |

## Verification
The hardest state to reach is a queue sitting at its exact capacity edge while the bus asks for a multi-byte transfer. That is a write of four bytes into 510 or 511 occupied bytes, or a three-byte sample read against two bytes present. It needs hundreds of one-byte engine operations first. Directed phases fill each queue to 512 bytes through the engine and bus paths and then probe one more access. A seeded random phase weights pushes and writes so that the levels drift back toward the edges under changing modes. Samples with the start-of-frame flag are also injected with set junk bits 7:5 and 3:0 in the third byte, to show the masking.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [2:0] {
    MD_UART = 3'd0,
    MD_SIR  = 3'd1,
    MD_BYTE = 3'd2,
    MD_C16  = 3'd3,
    MD_C24  = 3'd4,
    MD_C32  = 3'd5,
    MD_AUD  = 3'd6,
    MD_NONE = 3'd7
  } sdp_mode_e;

  // bytes moved by one access; 0 marks a refused size
  function automatic logic [2:0] access_bytes(logic [2:0] mode, logic [1:0] size);
    logic [2:0] n;
    n = 3'd0;
    case (mode)
      MD_UART, MD_SIR, MD_BYTE:
        case (size)
          2'd0: n = 3'd1;
          2'd1: n = 3'd2;
          2'd2: n = 3'd4;
          default: n = 3'd0;
        endcase
      MD_C16: n = (size == 2'd1) ? 3'd2 : (size == 2'd2) ? 3'd4 : 3'd0;
      MD_C24: n = (size == 2'd2) ? 3'd3 : 3'd0;
      MD_C32: n = (size == 2'd2) ? 3'd4 : 3'd0;
      MD_AUD: n = (size == 2'd2) ? 3'd3 : 3'd0;
      default: n = 3'd0;
    endcase
    return n;
  endfunction

  function automatic logic fits(int level, int n, int cap);
    return (level + n) <= cap;
  endfunction

  // word to queue lanes (lane 0 goes first)
  function automatic logic [31:0] pack_write(logic [2:0] mode, logic [31:0] w);
    logic [31:0] r;
    case (mode)
      MD_C24: r = {8'h00, w[23:0]};
      MD_AUD: r = {8'h00, 3'b000, w[20], (w[20] ? 4'h0 : w[19:16]), w[15:0]};
      default: r = w;
    endcase
    return r;
  endfunction

  // queue lanes to word, n bytes taken
  function automatic logic [31:0] unpack_read(logic [2:0] mode, logic [2:0] n, logic [31:0] raw);
    logic [31:0] r;
    if (mode == MD_AUD) begin
      r = {11'd0, raw[20], (raw[20] ? 4'h0 : raw[19:16]), raw[15:0]};
    end else begin
      case (n)
        3'd1: r = {24'd0, raw[7:0]};
        3'd2: r = {16'd0, raw[15:0]};
        3'd3: r = {8'd0, raw[23:0]};
        default: r = raw;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/sdp_fifo.sv
module sdp_fifo #(
  parameter int DEPTH = 512,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(PUSH_LANES+1)-1:0]  push_n,
  input  logic [8*PUSH_LANES-1:0]          push_data,
  input  logic [$clog2(POP_LANES+1)-1:0]   pop_n,
  output logic [8*POP_LANES-1:0]           head_data,
  output logic [$clog2(DEPTH+1)-1:0]       level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // caller guarantees push_n fits and pop_n <= level
  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_LANES; k++) begin
      if (k < int'(push_n)) mem[wr_ptr + AW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + LW'(push_n) - LW'(pop_n);
    end
  end

  for (genvar k = 0; k < POP_LANES; k++) begin : g_head
    assign head_data[8*k +: 8] = mem[rd_ptr + AW'(k)];
  end

endmodule

// File: rtl/sdp_access.sv
module sdp_access import sdp_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic [2:0]                   mode,
  input  logic [1:0]                   size,
  input  logic                         is_wr,
  input  logic                         is_rd,
  input  logic                         via_alias,
  input  logic                         tx_enable,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  output logic [2:0]                   acc_n,
  output logic                         wr_gated,
  output logic                         wr_bad,
  output logic                         wr_ovf,
  output logic                         wr_push,
  output logic                         rd_bad,
  output logic                         rd_unf,
  output logic                         rd_pop
);
  logic legal;
  logic serial_gate;

  assign acc_n       = access_bytes(mode, size);
  assign legal       = (acc_n != 3'd0);
  assign serial_gate = (mode == MD_UART || mode == MD_SIR) && !tx_enable && !via_alias;

  assign wr_gated = is_wr && serial_gate;
  assign wr_bad   = is_wr && !serial_gate && !legal;
  assign wr_ovf   = is_wr && !serial_gate && legal &&
                    !fits(int'(tx_level), int'(acc_n), DEPTH);
  assign wr_push  = is_wr && !serial_gate && legal && !wr_ovf;

  assign rd_bad = is_rd && !legal;
  assign rd_unf = is_rd && legal && (int'(rx_level) < int'(acc_n));
  assign rd_pop = is_rd && legal && !rd_unf;

endmodule

// File: rtl/serdata_port.sv
module serdata_port import sdp_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 mode,
  input  logic                       tx_enable,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic                       bus_alias,
  input  logic [1:0]                 bus_size,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       size_err,
  output logic                       tx_overflow,
  output logic                       rx_underflow,
  input  logic                       tx_pop,
  output logic [7:0]                 tx_data,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  input  logic                       rx_push,
  input  logic [7:0]                 rx_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_level
);
  localparam int LW = $clog2(DEPTH+1);

  logic [2:0]  acc_n;
  logic        wr_gated, wr_bad, wr_ovf, wr_push;
  logic        rd_bad, rd_unf, rd_pop;
  logic        eng_pop, eng_push;
  logic [31:0] rx_head;
  logic [31:0] rd_word;

  sdp_access #(.DEPTH(DEPTH)) u_acc (
    .mode(mode), .size(bus_size), .is_wr(bus_wr), .is_rd(bus_rd),
    .via_alias(bus_alias), .tx_enable(tx_enable),
    .tx_level(tx_level), .rx_level(rx_level),
    .acc_n(acc_n), .wr_gated(wr_gated), .wr_bad(wr_bad), .wr_ovf(wr_ovf),
    .wr_push(wr_push), .rd_bad(rd_bad), .rd_unf(rd_unf), .rd_pop(rd_pop)
  );

  assign eng_pop  = tx_pop && (tx_level != LW'(0));
  assign eng_push = rx_push && (rx_level != LW'(DEPTH));

  sdp_fifo #(.DEPTH(DEPTH), .PUSH_LANES(4), .POP_LANES(1)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_n(wr_push ? acc_n : 3'd0),
    .push_data(pack_write(mode, bus_wdata)),
    .pop_n(eng_pop),
    .head_data(tx_data),
    .level(tx_level)
  );

  sdp_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(4)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_n(eng_push),
    .push_data(rx_data),
    .pop_n(rd_pop ? acc_n : 3'd0),
    .head_data(rx_head),
    .level(rx_level)
  );

  assign rd_word = rd_pop ? unpack_read(mode, acc_n, rx_head) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      size_err     <= 1'b0;
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      if (wr_bad || rd_bad) size_err <= 1'b1;
      if (wr_ovf) tx_overflow <= 1'b1;
      if (rd_unf) rx_underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int DEPTH = 512
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 mode,
  input logic                       tx_pop,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic [31:0]                bus_rdata,
  input logic                       size_err,
  input logic                       tx_overflow,
  input logic                       rx_underflow,
  input logic                       wr_gated,
  input logic                       wr_bad,
  input logic                       wr_ovf,
  input logic                       rd_bad,
  input logic                       rd_unf,
  input logic                       rd_pop
);
  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

  // R7
  size_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad || rd_bad) |=> size_err);

  // R7
  size_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  // R8
  gated_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gated && !tx_pop) |=> (tx_level == $past(tx_level)));

  // R9
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |=> (tx_overflow && (tx_level <= $past(tx_level))));

  // R10
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unf |=> (rx_underflow && bus_rdata == 32'd0));

  // R6
  sample_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && mode == 3'd6) |=> (bus_rdata[31:21] == 11'd0));

endmodule

bind serdata_port sdp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tx_pop(tx_pop),
  .tx_level(tx_level), .rx_level(rx_level), .bus_rdata(bus_rdata),
  .size_err(size_err), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow),
  .wr_gated(wr_gated), .wr_bad(wr_bad), .wr_ovf(wr_ovf),
  .rd_bad(rd_bad), .rd_unf(rd_unf), .rd_pop(rd_pop)
);

// File: tb/serdata_port_test.sv
module serdata_port_test;
  localparam int CAP = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd2;
  logic        tx_enable = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_alias = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        size_err, tx_overflow, rx_underflow;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic [9:0]  tx_level;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic [9:0]  rx_level;

  int checks = 0;
  int errors = 0;
  logic [7:0]  tq[$];
  logic [7:0]  rq[$];
  logic        e_err = 0, e_ovf = 0, e_unf = 0;
  logic [31:0] e_rdata = 0;

  always #10 clk = ~clk;

  serdata_port uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_enable(tx_enable),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_alias(bus_alias), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .size_err(size_err),
    .tx_overflow(tx_overflow), .rx_underflow(rx_underflow), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_level(tx_level), .rx_push(rx_push), .rx_data(rx_data),
    .rx_level(rx_level)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // byte count per requirement table R2-R7
  function automatic int bcount(int m, int s);
    if (s == 3 || m == 7) return 0;
    if (m <= 2) return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    if (m == 3) return (s == 0) ? 0 : (s == 1) ? 2 : 4;
    if (s != 2) return 0;
    return (m == 5) ? 4 : 3;
  endfunction

  function automatic logic [7:0] wbyte(int m, logic [31:0] w, int k);
    logic [19:0] smp;
    if (m == 6) begin
      smp = w[20] ? {4'h0, w[15:0]} : w[19:0];
      if (k == 2) return {3'b000, w[20], smp[19:16]};
      return smp[8*k +: 8];
    end
    return w[8*k +: 8];
  endfunction

  task automatic state(string tag);
    chk({tag, " txlvl"}, 32'(tx_level), 32'(tq.size()));
    chk({tag, " rxlvl"}, 32'(rx_level), 32'(rq.size()));
    chk({tag, " flags"}, {29'd0, size_err, tx_overflow, rx_underflow}, {29'd0, e_err, e_ovf, e_unf});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tq.delete(); rq.delete();
    e_err = 0; e_ovf = 0; e_unf = 0; e_rdata = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(bit al, int s, logic [31:0] w, string tag);
    int n;
    bit gated;
    n = bcount(int'(mode), s);
    gated = (mode <= 3'd1) && !tx_enable && !al;
    bus_wr = 1'b1; bus_alias = al; bus_size = 2'(s); bus_wdata = w;
    if (!gated) begin
      if (n == 0) e_err = 1;
      else if (tq.size() + n > CAP) e_ovf = 1;
      else for (int k = 0; k < n; k++) tq.push_back(wbyte(int'(mode), w, k));
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_alias = 1'b0;
    state(tag);
  endtask

  task automatic do_read(int s, string tag);
    int n;
    logic [7:0] b [4];
    n = bcount(int'(mode), s);
    bus_rd = 1'b1; bus_size = 2'(s);
    e_rdata = 0;
    if (n == 0) e_err = 1;
    else if (rq.size() < n) e_unf = 1;
    else begin
      for (int k = 0; k < 4; k++) b[k] = (k < n) ? rq.pop_front() : 8'h00;
      if (mode == 3'd6)
        e_rdata = b[2][4] ? {11'd0, 1'b1, 4'h0, b[1], b[0]}
                          : {11'd0, 1'b0, b[2][3:0], b[1], b[0]};
      else
        e_rdata = {b[3], b[2], b[1], b[0]};
    end
    @(negedge clk);
    bus_rd = 1'b0;
    chk({tag, " rdata"}, bus_rdata, e_rdata);
    state(tag);
  endtask

  task automatic eng_pop(string tag);
    if (tq.size() > 0) chk({tag, " txdata"}, 32'(tx_data), 32'(tq.pop_front()));
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    state(tag);
  endtask

  task automatic eng_push(logic [7:0] d, bit quiet);
    if (rq.size() < CAP) rq.push_back(d);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
    if (!quiet) state("R11 push");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'd0);
    state("R1");

    // R2 byte stream order
    mode = 3'd2; tx_enable = 1'b0;
    do_write(0, 0, 32'h0000_00AB, "R2 w1");
    do_write(0, 1, 32'hFFFF_1234, "R2 w2");
    do_write(0, 2, 32'hDDCC_BBAA, "R2 w4");
    for (int i = 0; i < 7; i++) eng_pop("R2 order");

    // R8 gating in serial modes
    mode = 3'd0;
    do_write(0, 2, 32'h1111_1111, "R8 gated");
    do_write(1, 1, 32'h0000_5A5B, "R8 alias");
    mode = 3'd1;
    do_write(0, 0, 32'h0000_0077, "R8 gated sir");
    tx_enable = 1'b1;
    do_write(0, 0, 32'h0000_0066, "R8 enabled");
    for (int i = 0; i < 3; i++) eng_pop("R8 drain");
    eng_pop("R11 pop empty");

    // R7 refused sizes
    mode = 3'd3;
    do_write(0, 0, 32'h0000_0099, "R7 c16 byte");
    do_reset();
    mode = 3'd7;
    eng_push(8'h01, 0);
    do_read(2, "R7 mode7 read");
    do_reset();
    mode = 3'd5;
    do_write(0, 1, 32'h0000_1234, "R7 c32 half");
    do_reset();

    // R3 / R4 writes
    mode = 3'd3;
    do_write(0, 1, 32'h0000_BEEF, "R3 half");
    do_write(0, 2, 32'h0102_0304, "R3 word");
    mode = 3'd4;
    do_write(0, 2, 32'hFF12_3456, "R4 write");
    for (int i = 0; i < 9; i++) eng_pop("R4 drain");

    // R5 / R4 reads
    for (int i = 1; i <= 7; i++) eng_push(8'(i * 17), 0);
    mode = 3'd5; do_read(2, "R5 read");
    mode = 3'd4; do_read(2, "R4 read");

    // R6 samples
    mode = 3'd6;
    eng_push(8'h34, 0); eng_push(8'h12, 0); eng_push(8'hFF, 0);
    do_read(2, "R6 tag read");
    eng_push(8'h78, 0); eng_push(8'h56, 0); eng_push(8'hEB, 0);
    do_read(2, "R6 slot read");
    do_write(0, 2, 32'hFFFF_FFFF, "R6 tag write");
    do_write(0, 2, 32'h000A_BCDE, "R6 slot write");
    for (int i = 0; i < 6; i++) eng_pop("R6 drain");

    // R12 hold
    @(negedge clk);
    chk("R12 hold", bus_rdata, e_rdata);

    // R10 underflow
    mode = 3'd2;
    eng_push(8'h42, 0);
    do_read(1, "R10 short");
    do_read(0, "R10 after");

    // R9 overflow at capacity edge
    do_reset();
    mode = 3'd5;
    for (int i = 0; i < 127; i++) do_write(0, 2, 32'(i * 32'h0101_0101), "R9 fill");
    mode = 3'd4;
    do_write(0, 2, 32'h00AB_CDEF, "R9 near");
    mode = 3'd2;
    do_write(0, 1, 32'h0000_7788, "R9 half over");
    do_write(0, 0, 32'h0000_0055, "R9 last byte");
    do_write(0, 0, 32'h0000_0056, "R9 full");

    // R11 receive full
    for (int i = 0; i < CAP + 1; i++) eng_push(8'(i), 1);
    state("R11 rx full");
    mode = 3'd6;
    do_read(2, "R6 junk read");

    // random phase
    do_reset();
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      mode = 3'($urandom_range(0, 7));
      tx_enable = 1'($urandom_range(0, 1));
      if (op <= 2) do_write(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), $urandom, "R9 rnd wr");
      else if (op <= 4) do_read(int'($urandom_range(0, 3)), "R10 rnd rd");
      else if (op == 5) eng_pop("R11 rnd pop");
      else eng_push(8'($urandom), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule